// File: doc/BRIEF.md
# Folded Second-Order Recursive Filter

This block is a second-order recursive filter in which the arithmetic is shared over a two-cycle frame. It has two adders and four multipliers. A two-state controller steers the operand multiplexers of the shared adders. In the first step of a frame, the four multipliers form the feedback and feed-forward products of the two stored state values, and the adders reduce them to two partial sums. In the second step, the same two adders close the recursion: they add the new sample to the feedback sum, and they add the new state to the feed-forward sum. Only one register separates the state from its own next value inside a frame, so the recursive loop closes in two cycles.

The filter computes `w = x + c1*w1 + c2*w2` and `y = w + d1*w1 + d2*w2`, where `w1` and `w2` are the two previous state values. Samples and coefficients are 16-bit two's complement Q1.15 values. Products are kept at full width until the final adder of each path. There the result is rounded and then saturated back to 16 bits. The block takes at most one sample every two cycles and returns one result per frame. Coefficients are written through a small select-and-write port.

Top module: `iir2f_top`

## Requirements
- R1: A write with `cfg_we` high stores `cfg_data` into the coefficient chosen by `cfg_sel`: 0 = c1 (feedback, newest state), 1 = c2 (feedback, older state), 2 = d1 (feed-forward, newest state), 3 = d2 (feed-forward, older state). Coefficients keep their value when no write occurs.
- R2: For each accepted sample x, the new state is w = sat(rnd(x·2^15 + c1·w1 + c2·w2)) and the output is y = sat(rnd(w·2^15 + d1·w1 + d2·w2)). After that, the older state takes the value of the newer state, and the newer state takes w.
- R3: Rounding adds 2^14 to the full-width sum and then shifts it arithmetically right by 15 bits, so exact halves round toward plus infinity.
- R4: A rounded value above 32767 is output as 32767, and a rounded value below -32768 is output as -32768. This applies to both the state and the output.
- R5: A sample is accepted only when `in_valid` is high and the controller is in its first step. An `in_valid` in the cycle right after an acceptance is ignored: it produces no output and leaves the state unchanged.
- R6: `out_valid` is high for exactly one cycle, starting two rising edges after the accepting edge. `out_data` changes only together with a rise of `out_valid`, and otherwise holds its value.
- R7: While `rst` is high at a rising edge, the state, the coefficients, the controller step, `out_valid` and `out_data` are all cleared to zero.
- R8: With `in_valid` held high, samples are accepted on every second rising edge, and one output is produced per accepted sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_sel | input | 2 | Coefficient select (0 c1, 1 c2, 2 d1, 3 d2) |
| cfg_data | input | 16 | Coefficient value, Q1.15 |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 16 | Input sample, Q1.15 |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | 16 | Filtered sample, Q1.15 |

## Verification
Two conditions are hard to reach from the ports. The first is a strobe that arrives during the second step of a frame, which the filter must drop. To produce it, the bench holds `in_valid` high across two edges with a different sample on the second edge. It then checks that only the first sample enters the recurrence and that the next real sample continues from the correct history. The second is saturation inside the feedback loop. The bench sets a feedback coefficient close to one and feeds a run of full-scale samples of each sign, which drives the stored state into its limit. Exact half-way rounding is reached with a 0.5 feed-forward coefficient applied to state values of plus and minus one.

// File: rtl/iir2f_pkg.sv
package iir2f_pkg;
  // Two schedule steps of a frame
  typedef enum logic {
    STEP_MUL = 1'b0,  // products of state, partial sums
    STEP_ACC = 1'b1   // close recursion, form output
  } step_e;

  // Coefficient slots (cfg_sel encoding)
  localparam int unsigned CI_FB1 = 0;
  localparam int unsigned CI_FB2 = 1;
  localparam int unsigned CI_FF1 = 2;
  localparam int unsigned CI_FF2 = 3;
  localparam int unsigned NCOEF  = 4;
endpackage

// File: rtl/iir2f_ctrl.sv
module iir2f_ctrl
  import iir2f_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  in_valid,
  output step_e step,
  output logic  accept,
  output logic  fin
);
  step_e step_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= STEP_MUL;
    end else begin
      case (step_q)
        STEP_MUL: if (in_valid) step_q <= STEP_ACC;
        default:  step_q <= STEP_MUL;
      endcase
    end
  end

  assign step   = step_q;
  assign accept = (step_q == STEP_MUL) && in_valid && !rst;
  assign fin    = (step_q == STEP_ACC) && !rst;
endmodule

// File: rtl/iir2f_mul.sv
module iir2f_mul #(
  parameter int DW   = 16,
  parameter int NMUL = 4
) (
  input  logic [NMUL-1:0][DW-1:0]   a,
  input  logic [NMUL-1:0][DW-1:0]   b,
  output logic [NMUL-1:0][2*DW-1:0] p
);
  for (genvar i = 0; i < NMUL; i++) begin : g_mul
    assign p[i] = $signed(a[i]) * $signed(b[i]);
  end
endmodule

// File: rtl/iir2f_add.sv
module iir2f_add
  import iir2f_pkg::*;
#(
  parameter int AW = 34
) (
  input  step_e          step,
  input  logic [AW-1:0]  m0,
  input  logic [AW-1:0]  m1,
  input  logic [AW-1:0]  a0,
  input  logic [AW-1:0]  a1,
  output logic [AW-1:0]  sum
);
  logic [AW-1:0] opx, opy;

  always_comb begin
    if (step == STEP_MUL) begin
      opx = m0;
      opy = m1;
    end else begin
      opx = a0;
      opy = a1;
    end
    sum = opx + opy;
  end
endmodule

// File: rtl/iir2f_top.sv
module iir2f_top
  import iir2f_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [DW-1:0] cfg_data,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);
  localparam int FRAC = DW - 1;
  localparam int PW   = 2 * DW;
  localparam int AW   = PW + 2;
  localparam int NADD = 2;
  localparam logic signed [AW-1:0] HALF = AW'(1) <<< (FRAC - 1);
  localparam logic signed [AW-1:0] MAXV = (AW'(1) <<< (DW - 1)) - AW'(1);
  localparam logic signed [AW-1:0] MINV = -MAXV - AW'(1);

  function automatic logic [DW-1:0] rnd_sat(input logic signed [AW-1:0] v);
    logic signed [AW-1:0] t;
    t = (v + HALF) >>> FRAC;
    if (t > MAXV)      return MAXV[DW-1:0];
    else if (t < MINV) return MINV[DW-1:0];
    else               return t[DW-1:0];
  endfunction

  step_e step;
  logic  accept, fin;

  logic [NCOEF-1:0][DW-1:0] coef_q;
  logic [DW-1:0] w1_q, w2_q, x_q;
  logic [NADD-1:0][AW-1:0] acc_q;
  logic [NCOEF-1:0][PW-1:0] prod;
  logic [NCOEF-1:0][AW-1:0] prod_x;
  logic [NADD-1:0][AW-1:0] add_a0, sum;
  logic [DW-1:0] w_new, y_new;

  iir2f_ctrl u_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .step(step), .accept(accept), .fin(fin)
  );

  // Coefficient slots
  always_ff @(posedge clk) begin
    if (rst)         coef_q <= '0;
    else if (cfg_we) coef_q[cfg_sel] <= cfg_data;
  end

  // Four shared multipliers: even slots use newest state, odd the older
  iir2f_mul #(.DW(DW), .NMUL(NCOEF)) u_mul (
    .a(coef_q),
    .b({w2_q, w1_q, w2_q, w1_q}),
    .p(prod)
  );

  for (genvar i = 0; i < NCOEF; i++) begin : g_ext
    assign prod_x[i] = {{(AW-PW){prod[i][PW-1]}}, prod[i]};
  end

  // Second-step operands: sample for the feedback path, new state for output
  assign add_a0[0] = {{(AW-DW-FRAC){x_q[DW-1]}}, x_q, {FRAC{1'b0}}};
  assign add_a0[1] = {{(AW-DW-FRAC){w_new[DW-1]}}, w_new, {FRAC{1'b0}}};

  for (genvar g = 0; g < NADD; g++) begin : g_add
    iir2f_add #(.AW(AW)) u_add (
      .step(step),
      .m0(prod_x[2*g]), .m1(prod_x[2*g+1]),
      .a0(add_a0[g]),   .a1(acc_q[g]),
      .sum(sum[g])
    );
  end

  assign w_new = rnd_sat(sum[0]);
  assign y_new = rnd_sat(sum[1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q       <= '0;
      acc_q     <= '0;
      w1_q      <= '0;
      w2_q      <= '0;
      out_data  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= fin;
      if (accept) begin
        x_q   <= in_data;
        acc_q <= sum;
      end
      if (fin) begin
        w1_q     <= w_new;
        w2_q     <= w1_q;
        out_data <= y_new;
      end
    end
  end
endmodule

// File: rtl/iir2f_chk.sv
module iir2f_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          cfg_we,
  input logic          accept,
  input logic          out_valid,
  input logic [DW-1:0] out_data,
  input logic [4*DW-1:0] coef_flat
);
  assert_valid_after_accept_R6: assert property (@(posedge clk) disable iff (rst)
    accept |=> ##1 out_valid);

  assert_valid_has_source_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(accept, 2));

  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  assert_data_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_data));

  assert_no_back_to_back_R8: assert property (@(posedge clk) disable iff (rst)
    accept |=> !accept);

  assert_coef_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> $stable(coef_flat));
endmodule

bind iir2f_top iir2f_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .accept(accept),
  .out_valid(out_valid), .out_data(out_data), .coef_flat(coef_q)
);

// File: tb/tb_iir2f_top.sv
module tb_iir2f_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [15:0] cfg_data = '0;
  logic in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic out_valid;
  logic [15:0] out_data;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  longint mw1, mw2;
  longint mc [4];

  localparam logic signed [15:0] STIM [16] = '{
    16'sd12000, -16'sd3000, 16'sd0, 16'sd32767, -16'sd32768, 16'sd7,
    16'sd20000, 16'sd20000, -16'sd15000, 16'sd1, -16'sd1, 16'sd4096,
    16'sd0, 16'sd0, -16'sd22222, 16'sd31000};

  always #4 clk = ~clk;

  iir2f_top dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint rs(input longint v);
    longint t;
    t = (v + 16384) >>> 15;
    if (t > 32767) t = 32767;
    if (t < -32768) t = -32768;
    return t;
  endfunction

  task automatic model_step(input longint x, output longint y);
    longint w;
    w = rs(x * 32768 + mc[0] * mw1 + mc[1] * mw2);
    y = rs(w * 32768 + mc[2] * mw1 + mc[3] * mw2);
    mw2 = mw1;
    mw1 = w;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    in_valid = 1'b0;
    cfg_we = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    mw1 = 0; mw2 = 0;
    for (int i = 0; i < 4; i++) mc[i] = 0;
  endtask

  task automatic load(input int sel, input longint v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_data = 16'(v);
    @(negedge clk);
    cfg_we = 1'b0;
    mc[sel] = v;
  endtask

  task automatic send(input longint x, input string req);
    longint y;
    @(negedge clk);
    in_valid = 1'b1; in_data = 16'(x);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R6 early", longint'(out_valid), 0);
    @(negedge clk);
    chk("R6 strobe", longint'(out_valid), 1);
    model_step(x, y);
    chk(req, longint'($signed(out_data)), y);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    longint ys [3];
    int cnt;
    do_reset();
    // R7: reset state
    chk("R7 valid", longint'(out_valid), 0);
    chk("R7 data", longint'(out_data), 0);

    // R1: impulse through d1 = 0.5 only
    load(2, 16384);
    send(16384, "R1");
    send(0, "R1");
    chk("R1 explicit", longint'($signed(out_data)), 8192);

    // R2: table walk with a full coefficient set
    load(0, 19661); load(1, -9830); load(2, -16384); load(3, 8192);
    for (int i = 0; i < 16; i++) send(STIM[i], "R2");

    // R3: exact halves
    do_reset();
    load(2, 16384);
    send(1, "R3");
    send(0, "R3");
    chk("R3 half up", longint'($signed(out_data)), 1);
    send(-1, "R3");
    send(0, "R3");
    chk("R3 neg half", longint'($signed(out_data)), 0);

    // R4: saturation in the loop, both signs
    do_reset();
    load(0, 32440);
    for (int i = 0; i < 5; i++) send(32767, "R4");
    chk("R4 pos", longint'($signed(out_data)), 32767);
    for (int i = 0; i < 6; i++) send(-32768, "R4");
    chk("R4 neg", longint'($signed(out_data)), -32768);

    // R5: strobe in second step is dropped
    do_reset();
    load(0, 16384); load(2, 8192); load(3, -4096);
    send(5000, "R5");
    @(negedge clk);
    in_valid = 1'b1; in_data = 16'sd9000;
    @(negedge clk);
    in_data = 16'sd30000;
    @(negedge clk);
    in_valid = 1'b0;
    begin
      longint y;
      model_step(9000, y);
      chk("R5 first", longint'($signed(out_data)), y);
    end
    @(negedge clk);
    chk("R5 no extra", longint'(out_valid), 0);
    @(negedge clk);
    chk("R5 no extra", longint'(out_valid), 0);
    send(-7000, "R5");

    // R8: continuous strobe
    for (int k = 0; k < 3; k++) model_step(3000, ys[k]);
    cnt = 0;
    @(negedge clk);
    in_valid = 1'b1; in_data = 16'sd3000;
    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      if (i == 5) in_valid = 1'b0;
      if (out_valid) begin
        if (cnt < 3) chk("R8 data", longint'($signed(out_data)), ys[cnt]);
        cnt++;
      end
    end
    chk("R8 count", cnt, 3);

    // R7: reset after activity clears state and coefficients
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 valid", longint'(out_valid), 0);
    chk("R7 data", longint'(out_data), 0);
    rst = 1'b0;
    mw1 = 0; mw2 = 0;
    for (int i = 0; i < 4; i++) mc[i] = 0;
    send(1234, "R7");
    chk("R7 passthru", longint'($signed(out_data)), 1234);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule